// File: doc/BRIEF.md
# Mode-Aware Bus-Shared GPIO Port

An eight-pin general-purpose port sits on a simple byte-wide CPU bus. Software sets which pins drive through a direction register that can be written but not read back. A data register holds the levels that output pins drive. A read-only pin-state register reports what each pin is doing. The operating mode decides the direction register's power-on value, and a warm reset does not disturb it.

In the modes that run an external bus, four pins (6 down to 3) are taken from software control. They carry the address-strobe, read, high-write and low-write strobes from the bus controller, and their direction bits have no effect there. When the chip enters software standby, an enable input picks one of two behaviours for those four strobe pins. They either freeze at their last level or release to high impedance.

Top module: `mode_gpio_port`

## Requirements
- R1: While rst_ni is low, the direction register loads 0x80 when mode_i is 1, 2, 4, 5 or 6 (expanded modes) and 0x00 when mode_i is 0, 3 or 7 (single-chip modes). The data register loads 0x00.
- R2: At a clock edge where hw_stby_i is high, both registers reload the same values as under R1, using the current mode_i.
- R3: At a clock edge where warm_rst_i is high, the data register clears to 0x00 and the direction register keeps its value. Bus writes are blocked at that edge. Software standby never changes the direction register.
- R4: A write with wr_i high and addr_i = 0xFEBE loads wdata_i into the direction register at that clock edge. A read of 0xFEBE returns 0xFF.
- R5: A write with wr_i high and addr_i = 0xFF6E loads wdata_i into the data register at that clock edge. A read of 0xFF6E returns the stored value. rdata_o follows addr_i combinationally.
- R6: A read of 0xFF5E returns, for each bit, the data register bit when the direction bit is 1, and otherwise the pad_i bit as it stood two clock edges earlier. Writes to 0xFF5E have no effect.
- R7: Outside the override of R8, pad_oe_o[i] equals direction bit i and pad_o[i] equals data bit i.
- R8: In expanded modes with sw_stby_i low, pad_oe_o[6:3] are all 1 and pad_o[6:3] = strobe_i[3:0]. The mapping is strobe_i[3] address strobe on pin 6, [2] read on pin 5, [1] high write on pin 4 and [0] low write on pin 3. The direction bits 6..3 are ignored.
- R9: In an expanded mode with sw_stby_i and hold_en_i high, pad_oe_o[6:3] stay 1. pad_o[6:3] hold the strobe_i value sampled at the last clock edge before sw_stby_i rose.
- R10: In an expanded mode with sw_stby_i high and hold_en_i low, pad_oe_o[6:3] and pad_o[6:3] are 0.
- R11: Reads of any other address return 0x00. Writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| hw_stby_i | input | 1 | Hardware standby, reloads mode defaults |
| warm_rst_i | input | 1 | Manual reset, clears data only |
| sw_stby_i | input | 1 | Software standby active |
| hold_en_i | input | 1 | 1: strobe pins hold level in standby; 0: float |
| mode_i | input | 3 | Operating mode 0..7 |
| addr_i | input | 16 | Bus address, low 16 bits |
| wr_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data |
| strobe_i | input | 4 | Bus-control strobes {as, rd, hwr, lwr} |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output levels |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
The hardest state to reach is a held strobe level during standby. It needs an expanded mode, a known strobe value captured at an edge, and standby raised together with a different strobe value before the next edge. The bench does exactly that. It then toggles the hold enable inside standby to see the float case, and leaves standby to confirm the pins return to live strobes with the direction register untouched. Synchronizer latency is checked by changing a pad at one edge and reading the pin-state register after one edge and again after two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_DIR, SEL_DATA, SEL_PIN} reg_sel_e;

  function automatic logic mode_is_expanded(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd4) || (m == 3'd5) || (m == 3'd6);
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned PW = 8,
  parameter int unsigned DIR_EXP_INIT = 32'h80,
  parameter int unsigned DIR_SC_INIT  = 32'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_stby_i,
  input  logic          warm_rst_i,
  input  logic          mode_exp_i,
  input  logic          wr_dir_i,
  input  logic          wr_data_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] dir_o,
  output logic [PW-1:0] data_o
);
  localparam logic [PW-1:0] DirExp = PW'(DIR_EXP_INIT);
  localparam logic [PW-1:0] DirSc  = PW'(DIR_SC_INIT);

  logic [PW-1:0] dir_q, data_q, dir_init;

  assign dir_init = mode_exp_i ? DirExp : DirSc;

  // mode-dependent power-on value of the direction register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= dir_init;
      data_q <= '0;
    end else if (hw_stby_i) begin
      dir_q  <= dir_init;
      data_q <= '0;
    end else if (warm_rst_i) begin
      data_q <= '0;
    end else begin
      if (wr_dir_i)  dir_q  <= wdata_i;
      if (wr_data_i) data_q <= wdata_i;
    end
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;

  assert_hw_stby_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (dir_q == ($past(mode_exp_i) ? DirExp : DirSc)) && (data_q == '0));

  assert_warm_keeps_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && !hw_stby_i) |=> $stable(dir_q) && (data_q == '0));

  assert_dir_only_by_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_dir_i && !hw_stby_i) |=> $stable(dir_q));

  assert_data_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && !hw_stby_i && !warm_rst_i) |=> (data_q == $past(wdata_i)));
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int unsigned PW      = 8,
  parameter int unsigned OVR_LSB = 3,
  parameter int unsigned OVR_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_exp_i,
  input  logic             sw_stby_i,
  input  logic             hold_en_i,
  input  logic [PW-1:0]    dir_i,
  input  logic [PW-1:0]    data_i,
  input  logic [OVR_W-1:0] strobe_i,
  output logic [PW-1:0]    pad_o,
  output logic [PW-1:0]    pad_oe_o
);
  logic [OVR_W-1:0] hold_q, strobe_cur;
  logic             float_act;

  // capture live strobes until standby begins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (!sw_stby_i) hold_q <= strobe_i;
  end

  assign float_act  = sw_stby_i && !hold_en_i;
  assign strobe_cur = sw_stby_i ? hold_q : strobe_i;

  for (genvar i = 0; i < PW; i++) begin : g_pin
    if (i >= OVR_LSB && i < OVR_LSB + OVR_W) begin : g_ovr
      assign pad_oe_o[i] = mode_exp_i ? !float_act : dir_i[i];
      assign pad_o[i]    = mode_exp_i ? (strobe_cur[i-OVR_LSB] && !float_act) : data_i[i];
    end else begin : g_gpio
      assign pad_oe_o[i] = dir_i[i];
      assign pad_o[i]    = data_i[i];
    end
  end

  assert_override_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_exp_i && !sw_stby_i) |-> (&pad_oe_o[OVR_LSB +: OVR_W]) &&
                                   (pad_o[OVR_LSB +: OVR_W] == strobe_i));

  assert_standby_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_exp_i && sw_stby_i && hold_en_i && $past(sw_stby_i) && $past(hold_en_i) &&
     $stable(mode_exp_i)) |-> $stable(pad_o[OVR_LSB +: OVR_W]));

  assert_standby_float_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_exp_i && sw_stby_i && !hold_en_i) |->
      (pad_oe_o[OVR_LSB +: OVR_W] == '0) && (pad_o[OVR_LSB +: OVR_W] == '0));

  assert_gpio_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_exp_i |-> (pad_oe_o == dir_i) && (pad_o == data_i));
endmodule

// File: rtl/mode_gpio_port.sv
module mode_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PW        = 8,
  parameter int unsigned AW        = 16,
  parameter logic [15:0] DIR_ADDR  = 16'hFEBE,
  parameter logic [15:0] DATA_ADDR = 16'hFF6E,
  parameter logic [15:0] PIN_ADDR  = 16'hFF5E,
  parameter int unsigned OVR_LSB   = 3,
  parameter int unsigned OVR_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_stby_i,
  input  logic             warm_rst_i,
  input  logic             sw_stby_i,
  input  logic             hold_en_i,
  input  logic [2:0]       mode_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic [PW-1:0]    wdata_i,
  output logic [PW-1:0]    rdata_o,
  input  logic [OVR_W-1:0] strobe_i,
  input  logic [PW-1:0]    pad_i,
  output logic [PW-1:0]    pad_o,
  output logic [PW-1:0]    pad_oe_o
);
  reg_sel_e      sel;
  logic          mode_exp;
  logic [PW-1:0] dir, data, pad_sync, pin_view;

  assign mode_exp = mode_is_expanded(mode_i);

  always_comb begin
    if (addr_i == AW'(DIR_ADDR))       sel = SEL_DIR;
    else if (addr_i == AW'(DATA_ADDR)) sel = SEL_DATA;
    else if (addr_i == AW'(PIN_ADDR))  sel = SEL_PIN;
    else                               sel = SEL_NONE;
  end

  gpio_port_regs #(.PW(PW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_stby_i  (hw_stby_i),
    .warm_rst_i (warm_rst_i),
    .mode_exp_i (mode_exp),
    .wr_dir_i   (wr_i && sel == SEL_DIR),
    .wr_data_i  (wr_i && sel == SEL_DATA),
    .wdata_i    (wdata_i),
    .dir_o      (dir),
    .data_o     (data)
  );

  gpio_port_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pad_sync)
  );

  gpio_port_pinmux #(.PW(PW), .OVR_LSB(OVR_LSB), .OVR_W(OVR_W)) u_pinmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_exp_i (mode_exp),
    .sw_stby_i  (sw_stby_i),
    .hold_en_i  (hold_en_i),
    .dir_i      (dir),
    .data_i     (data),
    .strobe_i   (strobe_i),
    .pad_o      (pad_o),
    .pad_oe_o   (pad_oe_o)
  );

  assign pin_view = (dir & data) | (~dir & pad_sync);

  always_comb begin
    unique case (sel)
      SEL_DIR:  rdata_o = '1;
      SEL_DATA: rdata_o = data;
      SEL_PIN:  rdata_o = pin_view;
      default:  rdata_o = '0;
    endcase
  end

  assert_pin_write_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == SEL_PIN && !hw_stby_i && !warm_rst_i) |=> $stable(data) && $stable(dir));

  assert_unmapped_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == SEL_NONE && !hw_stby_i && !warm_rst_i) |=> $stable(data) && $stable(dir));

  assert_dir_unreadable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_DIR) |-> (rdata_o == '1));
endmodule

// File: tb/mode_gpio_port_test.sv
module mode_gpio_port_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_stby = 1'b0, warm_rst = 1'b0, sw_stby = 1'b0, hold_en = 1'b0;
  logic [2:0] mode = 3'd7;
  logic [15:0] addr = 16'h0000;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00, rdata, pad_in = 8'h3C, pad_out, pad_oe;
  logic [3:0] strobe = 4'h0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mode_gpio_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_stby_i(hw_stby), .warm_rst_i(warm_rst),
    .sw_stby_i(sw_stby), .hold_en_i(hold_en), .mode_i(mode), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .strobe_i(strobe),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  // {addr, data, is_write, expected}
  localparam logic [32:0] VEC [10] = '{
    {16'hFF6E, 8'hA5, 1'b1, 8'h00},  // R5 write data
    {16'hFF6E, 8'h00, 1'b0, 8'hA5},  // R5 read back
    {16'hFEBE, 8'h0F, 1'b1, 8'h00},  // R4 write dir
    {16'hFEBE, 8'h00, 1'b0, 8'hFF},  // R4 unreadable
    {16'hFF5E, 8'h00, 1'b0, 8'h35},  // R6 mixed view
    {16'hFF5E, 8'h00, 1'b1, 8'h00},  // R6 write ignored
    {16'hFF6E, 8'h00, 1'b0, 8'hA5},  // R6 data intact
    {16'h1234, 8'hFF, 1'b1, 8'h00},  // R11 stray write
    {16'h1234, 8'h00, 1'b0, 8'h00},  // R11 stray read
    {16'hFF6E, 8'h00, 1'b0, 8'hA5}   // R11 data intact
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic por(input logic [2:0] m);
    @(negedge clk); rst_ni = 1'b0; mode = m;
    @(negedge clk); rst_ni = 1'b1; #1;
  endtask

  task automatic pulse_hw(input logic [2:0] m);
    @(negedge clk); mode = m; hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 single-chip power-on
    por(3'd7);
    chk("R1 oe mode7", pad_oe, 8'h00);
    bus_read("R1 data reset", 16'hFF6E, 8'h00);
    chk("R7 pad_o mode7", pad_out, 8'h00);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][8]) bus_write(VEC[i][32:17], VEC[i][16:9]);
      else begin
        @(negedge clk);
        bus_read($sformatf("table %0d", i), VEC[i][32:17], VEC[i][7:0]);
      end
    end
    chk("R7 oe follows dir", pad_oe, 8'h0F);
    chk("R7 pad_o follows data", pad_out, 8'hA5);

    // R6 two-edge synchronizer latency, input pins 7..4
    @(negedge clk); pad_in = 8'hC3; addr = 16'hFF5E;
    @(negedge clk); #1; chk("R6 one edge", rdata, 8'h35);
    @(negedge clk); #1; chk("R6 two edges", rdata, 8'hC5);

    // R2 hardware standby reload
    pulse_hw(3'd7);
    chk("R2 oe mode7", pad_oe, 8'h00);
    bus_read("R2 data cleared", 16'hFF6E, 8'h00);
    pulse_hw(3'd1);
    chk("R2 oe mode1", pad_oe, 8'hF8);

    // R3 warm reset keeps direction
    pulse_hw(3'd7);
    bus_write(16'hFEBE, 8'h33);
    bus_write(16'hFF6E, 8'h5A);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0; #1;
    chk("R3 dir kept", pad_oe, 8'h33);
    chk("R3 pad data cleared", pad_out, 8'h00);
    bus_read("R3 data cleared", 16'hFF6E, 8'h00);

    // R1 expanded power-on
    por(3'd5);
    chk("R1 oe mode5", pad_oe, 8'hF8);

    // R8 override in expanded mode 4
    por(3'd4);
    strobe = 4'b1010;
    bus_write(16'hFEBE, 8'h00);
    bus_write(16'hFF6E, 8'h81);
    #1;
    chk("R8 oe ignores dir", pad_oe, 8'h78);
    chk("R8 strobes on pins", pad_out, 8'hD1);

    // R9 standby hold: new strobe value arrives with standby
    @(negedge clk); sw_stby = 1'b1; hold_en = 1'b1; strobe = 4'b0101; #1;
    chk("R9 held level", pad_out, 8'hD1);
    chk("R9 oe kept", pad_oe, 8'h78);
    @(negedge clk); @(negedge clk); #1;
    chk("R9 still held", pad_out, 8'hD1);

    // R10 float
    @(negedge clk); hold_en = 1'b0; #1;
    chk("R10 oe float", pad_oe, 8'h00);
    chk("R10 pad zero", pad_out, 8'h81);

    // leave standby: live strobes, dir intact (R3)
    @(negedge clk); sw_stby = 1'b0; #1;
    chk("R3 dir survives standby", pad_oe, 8'h78);
    chk("R8 live strobes", pad_out, 8'hA9);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule